// File: doc/BRIEF.md
# Floating-Point Format Converter

This block re-encodes a binary floating-point value from one width and layout into another, with no clock and no state. Each side is described by a total width and an exponent width. The significand holds the rest of the bits, and its count includes the implicit leading one. The block can widen or narrow the exponent and the significand independently. It therefore covers exact widening, lossy narrowing, and the mixed cases such as a 32-bit word to a 16-bit word with an 8-bit exponent.

The rounding direction is fixed when the block is elaborated, through a five-bit one-hot parameter. There is no runtime rounding input, and there are no exception flags. Elaboration stops if:
- an exponent width is not strictly between zero and its total width;
- the output leaves no fraction bit for a NaN;
- the rounding code is not one of the five legal codes.

Zeros, infinities, subnormals, NaN, overflow and underflow are all handled.

Top module: `fp_format_conv`

## Requirements
- R1: Both formats use sign in the top bit, then the biased exponent, then the fraction in the low bits. With the default parameters (32 bits total and 8 exponent bits on both sides), every input that is not a NaN appears at the output unchanged.
- R2: A zero input (exponent and fraction all zero) gives a zero output with the same sign.
- R3: An infinite input (exponent all ones, fraction zero) gives an infinite output with the same sign.
- R4: Any NaN input gives the canonical quiet NaN of the output format: sign 0, exponent all ones, and only the top fraction bit set. No other NaN pattern ever leaves the block.
- R5: With rounding code 5'b00001, inexact results go to the nearest representable value, and ties go to the value with an even last fraction bit.
- R6: With code 5'b00010, inexact results go to the nearest value, and ties go away from zero.
- R7: With code 5'b00100, inexact results go toward positive infinity.
- R8: With code 5'b01000, inexact results go toward negative infinity.
- R9: With code 5'b10000, inexact results are truncated toward zero, and a finite input never produces infinity.
- R10: When the rounded magnitude exceeds the output range, the result is infinity under codes 00001 and 00010. It is also infinity when the direction points away from zero (00100 for positive, 01000 for negative). Otherwise the result is the largest finite value. The sign is kept in every case.
- R11: Values below the output's normal range round into a subnormal or a signed zero under the active mode. Rounding up from the largest subnormal gives the smallest normal.
- R12: When the output format is wider, input subnormals are normalised exactly into the output's normal range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input     | IW    | Value in the input format |
| dout | output    | OW    | Value re-encoded in the output format |

## Verification
The block is purely combinational, so a wrong intermediate value shows at `dout` within the same cycle as the input that triggers it. There is no hidden state that could delay or mask a fault.

The faults most likely to escape notice are the following:
- a leading-zero count that is off by one, which shifts a widened subnormal by a factor of two;
- a lost sticky bit, which flips round-to-even ties and directed rounding of far-underflowing values;
- a mis-scaled exponent bias, which moves every normal result.

Ties, values one ulp around the overflow threshold, values just below the smallest subnormal, and subnormal inputs to a wider format are therefore all driven on purpose, in every rounding mode.

// File: rtl/fp_format_conv.sv
module fp_format_conv #(
  parameter int IW = 32,
  parameter int IE = 8,
  parameter int OW = 32,
  parameter int OE = 8,
  parameter logic [4:0] RM = 5'b00001
) (
  input  logic [IW-1:0] din,
  output logic [OW-1:0] dout
);
  localparam int ISIG  = IW - IE;
  localparam int IFB   = ISIG - 1;
  localparam int OSIG  = OW - OE;
  localparam int OFB   = OSIG - 1;
  localparam int IBIAS = (1 << (IE - 1)) - 1;
  localparam int OBIAS = (1 << (OE - 1)) - 1;
  localparam int MAXE  = (IE > OE) ? IE : OE;
  localparam int EW    = MAXE + $clog2(ISIG + 2) + 3;
  localparam int XW    = ISIG + OSIG + 1;
  localparam int SW    = $clog2(XW + 1) + 1;
  localparam int MW    = EW + OSIG + 1;
  localparam int LW    = $clog2(ISIG + 1);
  localparam logic [OW-2:0] INF_M = (OW-1)'({OE{1'b1}}) << OFB;
  localparam logic [OW-1:0] QNAN  = {1'b0, INF_M} | (OW'(1) << (OFB - 1));
  localparam logic [ISIG-1:0] FMASK = ISIG'((64'd1 << IFB) - 64'd1);

  if (IE < 1 || IE >= IW) begin : g_bad_in_exp
    $error("input exponent width must lie strictly between 0 and the input width");
  end
  if (OE < 1 || OE > OW - 2) begin : g_bad_out_exp
    $error("output exponent width must leave at least one fraction bit");
  end
  if (RM != 5'b00001 && RM != 5'b00010 && RM != 5'b00100 &&
      RM != 5'b01000 && RM != 5'b10000) begin : g_bad_rm
    $error("rounding code must be a single fixed one-hot mode");
  end

  logic sgn;
  logic [IE-1:0] ief;
  logic [ISIG-1:0] fv;
  logic is_nan, is_inf, is_zero, is_sub;

  assign sgn     = din[IW-1];
  assign ief     = din[IW-2 -: IE];
  assign fv      = din[ISIG-1:0] & FMASK;
  assign is_nan  = (&ief) & (|fv);
  assign is_inf  = (&ief) & ~(|fv);
  assign is_zero = ~(|ief) & ~(|fv);
  assign is_sub  = ~(|ief) & (|fv);

  logic [LW-1:0] lzc;
  always_comb begin
    lzc = LW'(ISIG);
    for (int k = 0; k < ISIG; k++)
      if (fv[k]) lzc = LW'(ISIG - 1 - k);
  end

  logic [ISIG-1:0] mant;
  logic signed [EW-1:0] be;
  logic norm_rng;
  logic [EW-1:0] shf_full;
  logic [SW-1:0] shf;

  assign mant     = is_sub ? (fv << lzc) : (fv | (ISIG'(1) << IFB));
  assign be       = is_sub ? (EW'(1 - IBIAS + OBIAS) - EW'(lzc))
                           : (EW'(ief) + EW'(OBIAS - IBIAS));
  assign norm_rng = ~be[EW-1] & (|be);
  assign shf_full = EW'(1) - be;
  assign shf      = norm_rng ? SW'(0)
                  : ((shf_full > EW'(XW)) ? SW'(XW) : SW'(shf_full));

  logic [XW-1:0] xv, shv;
  logic [OSIG-1:0] kept;
  logic grd, stk, lost, inc;
  logic [OSIG:0] rnd;
  logic [MW-1:0] mag;
  logic ovf, to_inf;

  assign xv   = {mant, (OSIG+1)'(0)};
  assign shv  = xv >> shf;
  assign lost = |(xv & ~({XW{1'b1}} << shf));
  assign kept = shv[XW-1 -: OSIG];
  assign grd  = shv[XW-OSIG-1];
  assign stk  = (|shv[XW-OSIG-2:0]) | lost;

  always_comb begin
    case (RM)
      5'b00001: inc = grd & (stk | kept[0]);
      5'b00010: inc = grd;
      5'b00100: inc = ~sgn & (grd | stk);
      5'b01000: inc = sgn & (grd | stk);
      default:  inc = 1'b0;
    endcase
  end

  assign rnd    = {1'b0, kept} + (OSIG+1)'(inc);
  assign mag    = norm_rng ? ((MW'(be - EW'(1)) << OFB) + MW'(rnd)) : MW'(rnd);
  assign ovf    = mag >= MW'(INF_M);
  assign to_inf = RM[0] | RM[1] | (RM[2] & ~sgn) | (RM[3] & sgn);

  always_comb begin
    if (is_nan)       dout = QNAN;
    else if (is_inf)  dout = {sgn, INF_M};
    else if (is_zero) dout = {sgn, (OW-1)'(0)};
    else if (ovf)     dout = to_inf ? {sgn, INF_M} : {sgn, INF_M - (OW-1)'(1)};
    else              dout = {sgn, mag[OW-2:0]};
  end

  always_comb begin
    assert_sign_kept_R2: assert (is_nan || dout[OW-1] == sgn);
    assert_zero_in_zero_out_R2: assert (!is_zero || dout[OW-2:0] == '0);
    assert_nan_canonical_R4: assert (!((dout[OW-2:OFB] == {OE{1'b1}}) && (|dout[OFB-1:0])) || dout == QNAN);
    assert_nan_only_from_nan_R4: assert (dout != QNAN || is_nan);
    assert_rtz_no_inf_R9: assert (!(RM == 5'b10000 && dout[OW-2:0] == INF_M) || is_inf);
  end
endmodule

// File: tb/fp_format_conv_bench.sv
module fp_format_conv_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  logic [31:0] stim = '0;
  logic [31:0] def_o;
  logic [15:0] nar_o [5];
  logic [31:0] wid_o;
  logic [15:0] bfl_o;

  fp_format_conv u_fp_format_conv (.din(stim), .dout(def_o));

  for (genvar g = 0; g < 5; g++) begin : g_nar
    fp_format_conv #(.IW(32), .IE(8), .OW(16), .OE(5), .RM(5'b00001 << g))
      u_fp_format_conv_nar (.din(stim), .dout(nar_o[g]));
  end

  fp_format_conv #(.IW(16), .IE(5), .OW(32), .OE(8), .RM(5'b00001))
    u_fp_format_conv_wid (.din(stim[15:0]), .dout(wid_o));

  fp_format_conv #(.IW(32), .IE(8), .OW(16), .OE(8), .RM(5'b00010))
    u_fp_format_conv_bfl (.din(stim), .dout(bfl_o));

  function automatic longint ref_conv(longint x, int iw, int ie, int ow, int oe, int rm);
    int ifb = iw - ie - 1;
    int ofb = ow - oe - 1;
    int ibias = (1 << (ie - 1)) - 1;
    int obias = (1 << (oe - 1)) - 1;
    longint one = 64'd1;
    longint s = (x >> (iw - 1)) & 1;
    longint ef = (x >> ifb) & ((one << ie) - 1);
    longint fr = x & ((one << ifb) - 1);
    longint infm = ((one << oe) - 1) << ofb;
    longint sb = s << (ow - 1);
    longint m, n, rem, half, bits, k;
    int e, p, q, d, emin;
    bit inc, tinf, nz, above, tie;
    if (ef == (one << ie) - 1) begin
      if (fr != 0) return infm | (one << (ofb - 1));
      return sb | infm;
    end
    if (ef == 0 && fr == 0) return sb;
    if (ef == 0) begin m = fr; e = 1 - ibias - ifb; end
    else begin m = fr | (one << ifb); e = int'(ef) - ibias - ifb; end
    p = 0;
    for (int b = 0; b < 63; b++) if ((m >> b) & 1) p = b;
    emin = 1 - obias;
    q = p + e - ofb;
    if (q < emin - ofb) q = emin - ofb;
    d = q - e;
    nz = 0; above = 0; tie = 0;
    if (d <= 0) n = m << (-d);
    else if (d > 62) begin n = 0; nz = 1; end
    else begin
      n = m >> d;
      rem = m & ((one << d) - 1);
      half = one << (d - 1);
      nz = rem != 0; above = rem > half; tie = rem == half;
    end
    case (rm)
      1: inc = above || (tie && n[0]);
      2: inc = above || tie;
      4: inc = (s == 0) && nz;
      8: inc = (s == 1) && nz;
      default: inc = 0;
    endcase
    n = n + longint'(inc);
    tinf = (rm == 1) || (rm == 2) || (rm == 4 && s == 0) || (rm == 8 && s == 1);
    k = longint'(q - (emin - ofb));
    if (k >= (one << oe)) bits = infm;
    else bits = (k << ofb) + n;
    if (bits >= infm) return sb | (tinf ? infm : infm - 1);
    return sb | bits;
  endfunction

  task automatic check(string tag, longint got, longint exp, longint din);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s din=%h actual=%h expected=%h", tag, din, got, exp);
    end
  endtask

  function automatic string cls_tag(longint x, int iw, int ie);
    int ifb = iw - ie - 1;
    longint ef = (x >> ifb) & ((64'd1 << ie) - 1);
    longint fr = x & ((64'd1 << ifb) - 1);
    if (ef == (64'd1 << ie) - 1) return (fr != 0) ? "R4" : "R3";
    if (ef == 0 && fr == 0) return "R2";
    return "";
  endfunction

  task automatic check_all();
    string t;
    longint ex;
    t = cls_tag(stim, 32, 8);
    check((t == "R4") ? "R4" : "R1", def_o, ref_conv(stim, 32, 8, 32, 8, 1), stim);
    for (int g = 0; g < 5; g++) begin
      ex = ref_conv(stim, 32, 8, 16, 5, 1 << g);
      if (t == "") begin
        if ((ex & 16'h7fff) >= 16'h7bff) t = "R10";
        else if ((ex & 16'h7fff) < 16'h0400) t = "R11";
        else case (g)
          0: t = "R5";
          1: t = "R6";
          2: t = "R7";
          3: t = "R8";
          default: t = "R9";
        endcase
      end
      check(t, longint'(nar_o[g]), ex, stim);
      t = cls_tag(stim, 32, 8);
    end
    t = cls_tag(longint'(stim[15:0]), 16, 5);
    check((t == "") ? "R12" : t, wid_o, ref_conv(longint'(stim[15:0]), 16, 5, 32, 8, 1), longint'(stim[15:0]));
    t = cls_tag(stim, 32, 8);
    check((t == "") ? "R6" : t, longint'(bfl_o), ref_conv(stim, 32, 8, 16, 8, 2), stim);
  endtask

  task automatic apply(logic [31:0] v);
    @(posedge clk);
    stim <= v;
    @(negedge clk);
    check_all();
  endtask

  logic [31:0] directed [26] = '{
    32'h00000000, 32'h80000000, 32'h7f800000, 32'hff800000,
    32'h7fc00000, 32'hffa00001, 32'h3f801000, 32'h3f803000,
    32'hbf801000, 32'hbf803000, 32'h477ff000, 32'hc77ff000,
    32'h477fefff, 32'h7f7fffff, 32'hff7fffff, 32'h33800000,
    32'h33000000, 32'hb3000001, 32'h387fc000, 32'h387fe000,
    32'h00000001, 32'h807fffff, 32'h3f800001, 32'h00000003,
    32'h00008201, 32'h00003ff0
  };

  initial begin
    for (int i = 0; i < 26; i++) apply(directed[i]);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (i % 3 == 0) r[30:23] = 8'(100 + ($urandom % 50));
      if (i % 7 == 0) r[30:23] = 8'h00;
      if (i % 11 == 0) r[14:10] = 5'h00;
      apply(r);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule